// File: doc/BRIEF.md
# Dual-Port Mailbox Memory

This block is a clocked 2048 x 8 storage array with two fully independent access ports, called A and B. Each port has its own enable, write select, output enable, write-inhibit input, 11-bit address, write data, registered read data with a valid indication, and an active-low interrupt output. Either port may read or write any location in the same cycle as the other port.

On top of the storage sits a mailbox handshake between the two ports. The highest address (0x7FF) is the mailbox for port B, and the address one below it (0x7FE) is the mailbox for port A. When one port writes the other port's mailbox, the other port's interrupt goes low. The owning port drops its interrupt by accessing its own mailbox with enable and output enable both active. Both mailbox bytes stay ordinary memory that either side can read or write. An active write-inhibit input on a port blocks its memory write and also blocks the interrupt that the write would have raised.

Top module: `mbox_dpram`

## Requirements
- R1: Port A and port B each write a location when enable=1 and we=1 (we=1 selects write, we=0 selects read). Either port reads back any stored byte. Read data and rvalid=1 appear at the first clock edge after the read is presented.
- R2: A read needs enable=1, oe=1 and we=0. In every other cycle, rvalid is 0 at the next edge. While enable=0, a port changes neither the memory nor any interrupt.
- R3: When inh=1, a write cycle leaves the addressed location unchanged.
- R4: A write by port B to address 0x7FE drives a_irq_n low at the same clock edge that stores the data.
- R5: Port A releases a_irq_n (back to 1) by presenting address 0x7FE with enable=1 and oe=1. The level of we does not affect the release.
- R6: A write by port A to address 0x7FF drives b_irq_n low. Port B releases it by presenting 0x7FF with enable=1 and oe=1.
- R7: The bytes at 0x7FE and 0x7FF are stored and read back like any other location. Accessing them touches only the flag of the port that owns that mailbox.
- R8: A write with inh=1 to the peer's mailbox leaves the peer's interrupt unchanged.
- R9: When a set and a release of the same interrupt fall in one cycle, the interrupt ends low.
- R10: When one port writes an address and the other port reads the same address in the same cycle, the read returns the value held before the write.
- R11: When both ports write the same address in the same cycle, port A's data is stored.
- R12: After reset, a_irq_n and b_irq_n are 1 and both rvalid outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write select (1 write, 0 read) |
| a_oe | input | 1 | Port A output enable |
| a_inh | input | 1 | Port A write inhibit |
| a_addr | input | 11 | Port A address |
| a_wdata | input | 8 | Port A write data |
| a_rdata | output | 8 | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write select (1 write, 0 read) |
| b_oe | input | 1 | Port B output enable |
| b_inh | input | 1 | Port B write inhibit |
| b_addr | input | 11 | Port B address |
| b_wdata | input | 8 | Port B write data |
| b_rdata | output | 8 | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a mailbox write from one port and the owner's release access on the other; the bench presents both in one cycle and expects the interrupt to end low. The second pair is a write and a read of one cell from opposite ports; the bench presents both together and expects the old byte on the reader, then the new byte on a later read. A double write to one address is also forced, and the bench expects port A's byte to survive.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Decoded per-port intent for one cycle
  typedef struct packed {
    logic rd;        // registered read this cycle
    logic wr;        // committed write this cycle
    logic clr_own;   // release of this port's own interrupt
    logic set_peer;  // committed write into the peer's mailbox
  } port_op_t;

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
  input  logic              en,
  input  logic              we,
  input  logic              oe,
  input  logic              inh,
  input  logic [ADDR_W-1:0] addr,
  output port_op_t          op
);

  logic wr_ok;

  always_comb begin
    wr_ok       = en & we & ~inh;
    op.rd       = en & oe & ~we;
    op.wr       = wr_ok;
    op.clr_own  = en & oe & (addr == OWN_BOX);
    op.set_peer = wr_ok & (addr == PEER_BOX);
  end

endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);

  logic irq_n_q, irq_n_d, upd;

  always_comb begin
    upd     = set | clr;
    irq_n_d = set ? 1'b0 : 1'b1;   // set dominates a release
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_n_q <= 1'b1;
    else if (upd) irq_n_q <= irq_n_d;
  end

  assign irq_n = irq_n_q;

  a_r9_set_dominates: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> !irq_n);
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> irq_n);
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(irq_n));

endmodule

// File: rtl/mbox_mem.sv
module mbox_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr    [2],
  input  logic              rd    [2],
  input  logic [ADDR_W-1:0] addr  [2],
  input  logic [DATA_W-1:0] wdata [2],
  output logic [DATA_W-1:0] rdata [2],
  output logic              rvalid[2]
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Port 1 is applied first so port 0 overrides on a shared address
  always_ff @(posedge clk) begin
    if (wr[1]) mem[addr[1]] <= wdata[1];
    if (wr[0]) mem[addr[0]] <= wdata[0];
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    always_ff @(posedge clk) begin
      if (rd[p]) rdata_q <= mem[addr[p]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid_q <= 1'b0;
      else        rvalid_q <= rd[p];
    end

    assign rdata[p]  = rdata_q;
    assign rvalid[p] = rvalid_q;

    a_r1_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd[p] |=> rvalid[p]);
    a_r2_no_valid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      !rd[p] |=> !rvalid[p]);
  end

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic              a_oe,
  input  logic              a_inh,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  output logic              a_irq_n,
  input  logic              b_en,
  input  logic              b_we,
  input  logic              b_oe,
  input  logic              b_inh,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid,
  output logic              b_irq_n
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BOX_A = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] BOX_B = ADDR_W'(DEPTH - 1);

  port_op_t op_a, op_b;

  mbox_port_dec #(.ADDR_W(ADDR_W), .OWN_BOX(BOX_A), .PEER_BOX(BOX_B)) i_dec_a (
    .en(a_en), .we(a_we), .oe(a_oe), .inh(a_inh), .addr(a_addr), .op(op_a));

  mbox_port_dec #(.ADDR_W(ADDR_W), .OWN_BOX(BOX_B), .PEER_BOX(BOX_A)) i_dec_b (
    .en(b_en), .we(b_we), .oe(b_oe), .inh(b_inh), .addr(b_addr), .op(op_b));

  logic              m_wr    [2];
  logic              m_rd    [2];
  logic [ADDR_W-1:0] m_addr  [2];
  logic [DATA_W-1:0] m_wdata [2];
  logic [DATA_W-1:0] m_rdata [2];
  logic              m_rvalid[2];

  always_comb begin
    m_wr[0]    = op_a.wr;     m_wr[1]    = op_b.wr;
    m_rd[0]    = op_a.rd;     m_rd[1]    = op_b.rd;
    m_addr[0]  = a_addr;      m_addr[1]  = b_addr;
    m_wdata[0] = a_wdata;     m_wdata[1] = b_wdata;
  end

  mbox_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk(clk), .rst_n(rst_n), .wr(m_wr), .rd(m_rd), .addr(m_addr),
    .wdata(m_wdata), .rdata(m_rdata), .rvalid(m_rvalid));

  assign a_rdata  = m_rdata[0];
  assign a_rvalid = m_rvalid[0];
  assign b_rdata  = m_rdata[1];
  assign b_rvalid = m_rvalid[1];

  mbox_irq_flag i_flag_a (
    .clk(clk), .rst_n(rst_n), .set(op_b.set_peer), .clr(op_a.clr_own), .irq_n(a_irq_n));

  mbox_irq_flag i_flag_b (
    .clk(clk), .rst_n(rst_n), .set(op_a.set_peer), .clr(op_b.clr_own), .irq_n(b_irq_n));

  // Port-level checks of the mailbox handshake
  a_r4_peer_write_raises_a: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && b_we && !b_inh && b_addr == BOX_A) |=> !a_irq_n);
  a_r6_peer_write_raises_b: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_we && !a_inh && a_addr == BOX_B) |=> !b_irq_n);
  a_r8_inhibited_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (a_inh && !(a_en && a_we && !a_inh && a_addr == BOX_B)
     && !(b_en && b_oe && b_addr == BOX_B)) |=> $stable(b_irq_n));
  a_r12_irq_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_en && !b_en) |=> ($stable(a_irq_n) && $stable(b_irq_n)));

endmodule

// File: tb/test_mbox_dpram.sv
`timescale 1ns/1ps
module test_mbox_dpram;

  logic        clk, rst_n;
  logic        a_en, a_we, a_oe, a_inh, b_en, b_we, b_oe, b_inh;
  logic [10:0] a_addr, b_addr;
  logic [7:0]  a_wdata, b_wdata, a_rdata, b_rdata;
  logic        a_rvalid, b_rvalid, a_irq_n, b_irq_n;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  mbox_dpram i_mbox_dpram (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_oe(a_oe), .a_inh(a_inh), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_irq_n(a_irq_n),
    .b_en(b_en), .b_we(b_we), .b_oe(b_oe), .b_inh(b_inh), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_irq_n(b_irq_n));

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drv_a(input logic en, we, oe, inh, input logic [10:0] ad, input logic [7:0] d);
    a_en = en; a_we = we; a_oe = oe; a_inh = inh; a_addr = ad; a_wdata = d;
  endtask

  task automatic drv_b(input logic en, we, oe, inh, input logic [10:0] ad, input logic [7:0] d);
    b_en = en; b_we = we; b_oe = oe; b_inh = inh; b_addr = ad; b_wdata = d;
  endtask

  task automatic idle();
    drv_a(0, 0, 0, 0, '0, '0);
    drv_b(0, 0, 0, 0, '0, '0);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Single read on one port; result checked on the next falling edge
  task automatic rd_a(input logic [10:0] ad, input logic [7:0] exp, input string req);
    drv_a(1, 0, 1, 0, ad, '0); step();
    check(req, {7'd0, a_rvalid}, 8'd1);
    check(req, a_rdata, exp);
    idle();
  endtask

  task automatic rd_b(input logic [10:0] ad, input logic [7:0] exp, input string req);
    drv_b(1, 0, 1, 0, ad, '0); step();
    check(req, {7'd0, b_rvalid}, 8'd1);
    check(req, b_rdata, exp);
    idle();
  endtask

  task automatic t_reset();
    check("R12 a_irq_n", {7'd0, a_irq_n}, 8'd1);
    check("R12 b_irq_n", {7'd0, b_irq_n}, 8'd1);
    check("R12 a_rvalid", {7'd0, a_rvalid}, 8'd0);
    check("R12 b_rvalid", {7'd0, b_rvalid}, 8'd0);
  endtask

  task automatic t_basic();
    drv_a(1, 1, 0, 0, 11'h123, 8'h5A); step(); idle();
    rd_b(11'h123, 8'h5A, "R1 B reads A write");
    drv_b(1, 1, 0, 0, 11'h001, 8'hC3); step(); idle();
    rd_a(11'h001, 8'hC3, "R1 A reads B write");
  endtask

  task automatic t_gating();
    drv_a(1, 0, 0, 0, 11'h123, '0); step();
    check("R2 no oe no valid", {7'd0, a_rvalid}, 8'd0);
    drv_a(0, 1, 1, 0, 11'h123, 8'hFF); step();
    check("R2 disabled no valid", {7'd0, a_rvalid}, 8'd0);
    drv_a(1, 1, 1, 0, 11'h200, 8'h09); step();
    check("R2 write no valid", {7'd0, a_rvalid}, 8'd0);
    idle();
    rd_b(11'h123, 8'h5A, "R2 disabled write ignored");
    drv_b(0, 1, 1, 0, 11'h7FE, 8'h77); step(); idle();
    check("R2 disabled mailbox write no irq", {7'd0, a_irq_n}, 8'd1);
  endtask

  task automatic t_inhibit_write();
    drv_a(1, 1, 0, 0, 11'h010, 8'h3C); step();
    drv_a(1, 1, 0, 1, 11'h010, 8'hE1); step(); idle();
    rd_b(11'h010, 8'h3C, "R3 inhibited write");
  endtask

  task automatic t_a_mailbox();
    drv_b(1, 1, 0, 0, 11'h7FE, 8'h11); step(); idle();
    check("R4 a_irq_n set", {7'd0, a_irq_n}, 8'd0);
    check("R7 b_irq_n untouched", {7'd0, b_irq_n}, 8'd1);
    // release with we=1 (write blocked by inh) to show we is irrelevant
    drv_a(1, 1, 1, 1, 11'h7FE, 8'h99); step(); idle();
    check("R5 a_irq_n released", {7'd0, a_irq_n}, 8'd1);
    rd_a(11'h7FE, 8'h11, "R7 mailbox A data");
    check("R5 stays released", {7'd0, a_irq_n}, 8'd1);
  endtask

  task automatic t_b_mailbox();
    drv_a(1, 1, 0, 0, 11'h7FF, 8'h22); step(); idle();
    check("R6 b_irq_n set", {7'd0, b_irq_n}, 8'd0);
    check("R7 a_irq_n untouched", {7'd0, a_irq_n}, 8'd1);
    rd_a(11'h7FF, 8'h22, "R7 A reads B mailbox");
    check("R7 A read no release of B", {7'd0, b_irq_n}, 8'd0);
    rd_b(11'h7FF, 8'h22, "R6 B reads mailbox");
    check("R6 b_irq_n released", {7'd0, b_irq_n}, 8'd1);
  endtask

  task automatic t_inhibit_flag();
    drv_a(1, 1, 0, 1, 11'h7FF, 8'h66); step(); idle();
    check("R8 no irq on inhibited write", {7'd0, b_irq_n}, 8'd1);
    rd_b(11'h7FF, 8'h22, "R8 mailbox data kept");
  endtask

  task automatic t_set_wins();
    drv_b(1, 1, 0, 0, 11'h7FE, 8'h44);
    drv_a(1, 0, 1, 0, 11'h7FE, '0); step(); idle();
    check("R9 set beats release", {7'd0, a_irq_n}, 8'd0);
    check("R10 old mailbox byte", a_rdata, 8'h11);
    rd_a(11'h7FE, 8'h44, "R9 release after");
    check("R9 released later", {7'd0, a_irq_n}, 8'd1);
  endtask

  task automatic t_write_read_same();
    drv_a(1, 1, 0, 0, 11'h050, 8'h33); step();
    drv_a(1, 1, 0, 0, 11'h050, 8'h44);
    drv_b(1, 0, 1, 0, 11'h050, '0); step(); idle();
    check("R10 read sees old", b_rdata, 8'h33);
    rd_b(11'h050, 8'h44, "R10 new value later");
  endtask

  task automatic t_write_write_same();
    drv_a(1, 1, 0, 0, 11'h060, 8'hAA);
    drv_b(1, 1, 0, 0, 11'h060, 8'hBB); step(); idle();
    rd_b(11'h060, 8'hAA, "R11 port A wins");
  endtask

  initial begin
    rst_n = 0;
    idle();
    repeat (3) step();
    t_reset();
    rst_n = 1;
    step();
    t_basic();
    t_gating();
    t_inhibit_write();
    t_a_mailbox();
    t_b_mailbox();
    t_inhibit_flag();
    t_set_wins();
    t_write_read_same();
    t_write_write_same();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule